// File: doc/BRIEF.md
# Radio Transmit Enable Sequencer

This block orders the control lines of a radio front end for one transmission. A single-cycle transmit request starts a cycle counter. Four programmable delays then decide when the transmit enable, the baseband start strobe, the gain-ramp enable and the power amplifier enable come on. The request cycle counts as cycle 0, and each delay is a number of clock cycles from it. Once the ramp enable is high, a 6-bit transmit gain climbs toward a programmed target. It rises by a programmed step once per programmed interval and stops at the target. A mode input bypasses the ramp so that software drives the gain directly.

The physical layer reports the end of the frame on a done input. The block then drops every transmit output and clears the gain. When automatic switching is selected, it hands the radio back to receive. A request that arrives while a sequence is running is ignored. The configuration inputs are expected to stay stable during a sequence.

Top module: `txseq_top`

## Requirements
- R1: After reset, tx_en, tx_start, ramp_en and pa_en are 0, tx_gain and bb_gain are 0, and rx_en is 1.
- R2: Each of tx_en, ramp_en and pa_en is first high in cycle d, where d is its delay and the request cycle is cycle 0. Each then stays high through the cycle in which phy_done is seen.
- R3: An output whose delay is 0 is already high in the request cycle itself.
- R4: tx_start is high for exactly one cycle per sequence, in cycle d_start.
- R5: With ramp delay r, interval I and step s, hardware mode gives tx_gain = s * floor((c - r) / I) in cycle c >= r, and 0 before cycle r. An interval of 0 behaves as 1.
- R6: In hardware mode the ramped gain never exceeds cfg_gain_target and holds there once reached: tx_gain = min(target, s * floor((c - r) / I)).
- R7: With cfg_sw_gain_mode = 1, tx_gain equals cfg_sw_gain in every cycle of a sequence, including the request cycle.
- R8: bb_gain equals cfg_bb_gain (2 bits, 3 = full scale) during a sequence and is 0 otherwise.
- R9: In the cycle after phy_done is seen during a sequence, all transmit outputs are 0 and tx_gain is 0. A phy_done outside a sequence has no effect.
- R10: rx_en is 0 from the request cycle until the sequence ends. After the end, rx_en is 1 if cfg_auto_rx = 1 and stays 0 if cfg_auto_rx = 0.
- R11: A tx_req that arrives while a sequence runs is ignored: no output timing restarts and tx_start does not repeat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_req | input | 1 | Start of a transmit sequence |
| phy_done | input | 1 | Physical layer reports end of frame |
| cfg_dly_txen | input | DW (10) | Delay to transmit enable |
| cfg_dly_start | input | DW (10) | Delay to baseband start strobe |
| cfg_dly_ramp | input | DW (10) | Delay to gain-ramp enable |
| cfg_dly_pa | input | DW (10) | Delay to power amplifier enable |
| cfg_gain_target | input | GW (6) | Final ramp gain |
| cfg_gain_step | input | GW (6) | Gain increment per step |
| cfg_step_intv | input | IW (8) | Cycles between steps (0 acts as 1) |
| cfg_sw_gain_mode | input | 1 | 1 = software gain, 0 = hardware ramp |
| cfg_sw_gain | input | GW (6) | Gain used in software mode |
| cfg_bb_gain | input | BW (2) | Baseband gain code |
| cfg_auto_rx | input | 1 | Return to receive after done |
| tx_en | output | 1 | Transmit enable |
| tx_start | output | 1 | Baseband start strobe |
| ramp_en | output | 1 | Gain ramp enable |
| pa_en | output | 1 | Power amplifier enable |
| tx_gain | output | GW (6) | Transmit gain |
| bb_gain | output | BW (2) | Baseband gain applied during transmit |
| rx_en | output | 1 | Receive enable |

## Verification
The assertions check, on every cycle, rules that hold regardless of the delay values:
- tx_en and pa_en never overlap rx_en.
- tx_start never lasts two cycles.
- The enables stay up until done, and done clears them in the next cycle.
- The hardware gain never falls and never passes the target.

The exact cycle in which each output rises, the step timing of the ramp, the zero-delay and zero-interval cases, software gain mode, the receive hand-back in both switching modes, and ignored requests can only be shown by the bench's directed scenarios. Those scenarios compare every output against a cycle-indexed model.

// File: rtl/txseq_pkg.sv
package txseq_pkg;

    localparam int NUM_EV   = 4;
    localparam int EV_TXEN  = 0;
    localparam int EV_START = 1;
    localparam int EV_RAMP  = 2;
    localparam int EV_PA    = 3;

    localparam int GAIN_XW  = 8;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic busy;
        logic fire;
        logic clr;
    } seq_ctl_t;

    function automatic logic [GAIN_XW-1:0] ramp_step(
        input logic [GAIN_XW-1:0] cur,
        input logic [GAIN_XW-1:0] step,
        input logic [GAIN_XW-1:0] tgt
    );
        logic [GAIN_XW:0] sum;
        sum = {1'b0, cur} + {1'b0, step};
        if (sum > {1'b0, tgt})
            return tgt;
        return sum[GAIN_XW-1:0];
    endfunction

endpackage

// File: rtl/txseq_ctrl.sv
module txseq_ctrl
    import txseq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tx_req,
    input  logic     phy_done,
    input  logic     cfg_auto_rx,
    output seq_ctl_t ctl,
    output logic     rx_en
);

    seq_state_e state_q;
    logic       rx_q;
    logic       busy;
    logic       fire;
    logic       clr;

    assign busy = (state_q == ST_ACTIVE);
    assign fire = (state_q == ST_IDLE) && tx_req;
    assign clr  = busy && phy_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rx_q    <= 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (tx_req) begin
                        state_q <= ST_ACTIVE;
                        rx_q    <= 1'b0;
                    end
                end
                ST_ACTIVE: begin
                    if (phy_done) begin
                        state_q <= ST_IDLE;
                        rx_q    <= cfg_auto_rx;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ctl   = '{busy: busy, fire: fire, clr: clr};
    assign rx_en = rx_q && !fire;

endmodule

// File: rtl/txseq_timer.sv
module txseq_timer
    import txseq_pkg::*;
#(
    parameter int DW = 10
) (
    input  logic                        clk,
    input  logic                        rst,
    input  seq_ctl_t                    ctl,
    input  logic [NUM_EV-1:0][DW-1:0]   dly,
    output logic [NUM_EV-1:0]           lvl,
    output logic                        start_pulse
);

    localparam logic [DW-1:0] CNT_MAX = {DW{1'b1}};
    localparam logic [DW-1:0] CNT_ONE = DW'(1);

    logic [DW-1:0] cnt_q;
    logic          start_seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ctl.fire) begin
            cnt_q <= CNT_ONE;
        end else if (ctl.busy && !ctl.clr) begin
            if (cnt_q != CNT_MAX)
                cnt_q <= cnt_q + CNT_ONE;
        end else begin
            cnt_q <= '0;
        end
    end

    for (genvar e = 0; e < NUM_EV; e++) begin : g_ev
        assign lvl[e] = (ctl.busy && (cnt_q >= dly[e])) ||
                        (ctl.fire && (dly[e] == '0));
    end

    assign start_pulse = (ctl.busy && !start_seen_q && (cnt_q == dly[EV_START])) ||
                         (ctl.fire && (dly[EV_START] == '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            start_seen_q <= 1'b0;
        end else if (ctl.clr || (!ctl.busy && !ctl.fire)) begin
            start_seen_q <= 1'b0;
        end else if (start_pulse) begin
            start_seen_q <= 1'b1;
        end
    end

endmodule

// File: rtl/txseq_gain.sv
module txseq_gain
    import txseq_pkg::*;
#(
    parameter int GW = 6,
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  seq_ctl_t      ctl,
    input  logic          ramp_on,
    input  logic [GW-1:0] cfg_step,
    input  logic [GW-1:0] cfg_target,
    input  logic [IW-1:0] cfg_intv,
    output logic [GW-1:0] gain
);

    logic [GW-1:0] g_q;
    logic [IW:0]   t_q;
    logic [GW-1:0] g_base;
    logic [IW:0]   t_base;
    logic [IW:0]   intv_eff;
    logic [IW:0]   t_inc;
    logic          step_now;
    logic [GAIN_XW-1:0] g_stepped;

    assign g_base    = ctl.busy ? g_q : '0;
    assign t_base    = ctl.busy ? t_q : '0;
    assign intv_eff  = (cfg_intv == '0) ? (IW+1)'(1) : {1'b0, cfg_intv};
    assign t_inc     = t_base + (IW+1)'(1);
    assign step_now  = ramp_on && (t_inc >= intv_eff);
    assign g_stepped = ramp_step(GAIN_XW'(g_base), GAIN_XW'(cfg_step), GAIN_XW'(cfg_target));

    always_ff @(posedge clk) begin
        if (rst || ctl.clr || (!ctl.busy && !ctl.fire)) begin
            g_q <= '0;
            t_q <= '0;
        end else if (step_now) begin
            g_q <= GW'(g_stepped);
            t_q <= '0;
        end else if (ramp_on) begin
            g_q <= g_base;
            t_q <= t_inc;
        end else begin
            g_q <= g_base;
            t_q <= t_base;
        end
    end

    assign gain = g_q;

endmodule

// File: rtl/txseq_top.sv
module txseq_top
    import txseq_pkg::*;
#(
    parameter int DW = 10,
    parameter int GW = 6,
    parameter int IW = 8,
    parameter int BW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tx_req,
    input  logic          phy_done,
    input  logic [DW-1:0] cfg_dly_txen,
    input  logic [DW-1:0] cfg_dly_start,
    input  logic [DW-1:0] cfg_dly_ramp,
    input  logic [DW-1:0] cfg_dly_pa,
    input  logic [GW-1:0] cfg_gain_target,
    input  logic [GW-1:0] cfg_gain_step,
    input  logic [IW-1:0] cfg_step_intv,
    input  logic          cfg_sw_gain_mode,
    input  logic [GW-1:0] cfg_sw_gain,
    input  logic [BW-1:0] cfg_bb_gain,
    input  logic          cfg_auto_rx,
    output logic          tx_en,
    output logic          tx_start,
    output logic          ramp_en,
    output logic          pa_en,
    output logic [GW-1:0] tx_gain,
    output logic [BW-1:0] bb_gain,
    output logic          rx_en
);

    seq_ctl_t                  ctl;
    logic [NUM_EV-1:0][DW-1:0] dly;
    logic [NUM_EV-1:0]         lvl;
    logic                      start_pulse;
    logic [GW-1:0]             ramp_gain;
    logic                      active_now;
    logic                      busy;

    assign dly[EV_TXEN]  = cfg_dly_txen;
    assign dly[EV_START] = cfg_dly_start;
    assign dly[EV_RAMP]  = cfg_dly_ramp;
    assign dly[EV_PA]    = cfg_dly_pa;

    txseq_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .tx_req      (tx_req),
        .phy_done    (phy_done),
        .cfg_auto_rx (cfg_auto_rx),
        .ctl         (ctl),
        .rx_en       (rx_en)
    );

    txseq_timer #(.DW(DW)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .ctl         (ctl),
        .dly         (dly),
        .lvl         (lvl),
        .start_pulse (start_pulse)
    );

    txseq_gain #(.GW(GW), .IW(IW)) u_gain (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .ramp_on    (lvl[EV_RAMP] && !cfg_sw_gain_mode),
        .cfg_step   (cfg_gain_step),
        .cfg_target (cfg_gain_target),
        .cfg_intv   (cfg_step_intv),
        .gain       (ramp_gain)
    );

    assign busy       = ctl.busy;
    assign active_now = ctl.busy || ctl.fire;

    assign tx_en    = lvl[EV_TXEN];
    assign tx_start = start_pulse;
    assign ramp_en  = lvl[EV_RAMP];
    assign pa_en    = lvl[EV_PA];
    assign tx_gain  = !active_now ? '0 : (cfg_sw_gain_mode ? cfg_sw_gain : ramp_gain);
    assign bb_gain  = active_now ? cfg_bb_gain : '0;

endmodule

// File: rtl/txseq_chk.sv
module txseq_chk #(
    parameter int GW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          phy_done,
    input logic          cfg_sw_gain_mode,
    input logic [GW-1:0] cfg_gain_target,
    input logic          tx_en,
    input logic          tx_start,
    input logic          ramp_en,
    input logic          pa_en,
    input logic [GW-1:0] tx_gain,
    input logic          rx_en
);

    a_r2_level_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && tx_en && pa_en && !phy_done) |=> (tx_en && pa_en));

    a_r4_start_single: assert property (@(posedge clk) disable iff (rst)
        tx_start |=> !tx_start);

    a_r5_gain_monotonic: assert property (@(posedge clk) disable iff (rst)
        (busy && !phy_done && !cfg_sw_gain_mode) |=> (tx_gain >= $past(tx_gain)));

    a_r6_no_overshoot: assert property (@(posedge clk) disable iff (rst)
        (busy && !cfg_sw_gain_mode) |-> (tx_gain <= cfg_gain_target));

    a_r9_done_clears: assert property (@(posedge clk) disable iff (rst)
        (busy && phy_done) |=> (!tx_en && !ramp_en && !pa_en && tx_gain == '0));

    a_r10_rx_exclusive: assert property (@(posedge clk) disable iff (rst)
        rx_en |-> (!tx_en && !pa_en));

endmodule

bind txseq_top txseq_chk #(.GW(GW)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .busy             (busy),
    .phy_done         (phy_done),
    .cfg_sw_gain_mode (cfg_sw_gain_mode),
    .cfg_gain_target  (cfg_gain_target),
    .tx_en            (tx_en),
    .tx_start         (tx_start),
    .ramp_en          (ramp_en),
    .pa_en            (pa_en),
    .tx_gain          (tx_gain),
    .rx_en            (rx_en)
);

// File: tb/txseq_top_tb_top.sv
`timescale 1ns/1ps
module txseq_top_tb_top;

    localparam int DW = 10;
    localparam int GW = 6;
    localparam int IW = 8;
    localparam int BW = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          tx_req;
    logic          phy_done;
    logic [DW-1:0] cfg_dly_txen, cfg_dly_start, cfg_dly_ramp, cfg_dly_pa;
    logic [GW-1:0] cfg_gain_target, cfg_gain_step, cfg_sw_gain;
    logic [IW-1:0] cfg_step_intv;
    logic          cfg_sw_gain_mode;
    logic [BW-1:0] cfg_bb_gain;
    logic          cfg_auto_rx;
    logic          tx_en, tx_start, ramp_en, pa_en, rx_en;
    logic [GW-1:0] tx_gain;
    logic [BW-1:0] bb_gain;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    txseq_top #(.DW(DW), .GW(GW), .IW(IW), .BW(BW)) dut_i (
        .clk              (clk),
        .rst              (rst),
        .tx_req           (tx_req),
        .phy_done         (phy_done),
        .cfg_dly_txen     (cfg_dly_txen),
        .cfg_dly_start    (cfg_dly_start),
        .cfg_dly_ramp     (cfg_dly_ramp),
        .cfg_dly_pa       (cfg_dly_pa),
        .cfg_gain_target  (cfg_gain_target),
        .cfg_gain_step    (cfg_gain_step),
        .cfg_step_intv    (cfg_step_intv),
        .cfg_sw_gain_mode (cfg_sw_gain_mode),
        .cfg_sw_gain      (cfg_sw_gain),
        .cfg_bb_gain      (cfg_bb_gain),
        .cfg_auto_rx      (cfg_auto_rx),
        .tx_en            (tx_en),
        .tx_start         (tx_start),
        .ramp_en          (ramp_en),
        .pa_en            (pa_en),
        .tx_gain          (tx_gain),
        .bb_gain          (bb_gain),
        .rx_en            (rx_en)
    );

    task automatic chk(input string tag, input string what, input int cyc, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s cycle %0d: actual %0d expected %0d", tag, what, cyc, got, exp);
        end
    endtask

    task automatic run_case(
        input int d_en, input int d_st, input int d_rp, input int d_pa,
        input int intv, input int step, input int tgt,
        input int sw, input int swg, input int bb, input int auto_rx,
        input int done_at, input int inj_at,
        input string lvl_tag, input string st_tag, input string g_tag
    );
        int ieff;
        int eg;
        cfg_dly_txen     = DW'(d_en);
        cfg_dly_start    = DW'(d_st);
        cfg_dly_ramp     = DW'(d_rp);
        cfg_dly_pa       = DW'(d_pa);
        cfg_step_intv    = IW'(intv);
        cfg_gain_step    = GW'(step);
        cfg_gain_target  = GW'(tgt);
        cfg_sw_gain_mode = sw[0];
        cfg_sw_gain      = GW'(swg);
        cfg_bb_gain      = BW'(bb);
        cfg_auto_rx      = auto_rx[0];
        ieff = (intv == 0) ? 1 : intv;
        for (int c = 0; c <= done_at + 2; c++) begin
            @(negedge clk);
            tx_req   = (c == 0) || (c == inj_at);
            phy_done = (c == done_at);
            #1;
            if (c <= done_at) begin
                chk(lvl_tag, "tx_en", c, int'(tx_en), int'(c >= d_en));
                chk(lvl_tag, "ramp_en", c, int'(ramp_en), int'(c >= d_rp));
                chk(lvl_tag, "pa_en", c, int'(pa_en), int'(c >= d_pa));
                chk(st_tag, "tx_start", c, int'(tx_start), int'(c == d_st));
                if (sw != 0) eg = swg;
                else if (c < d_rp) eg = 0;
                else begin
                    eg = step * ((c - d_rp) / ieff);
                    if (eg > tgt) eg = tgt;
                end
                chk(g_tag, "tx_gain", c, int'(tx_gain), eg);
                chk("R8", "bb_gain", c, int'(bb_gain), bb);
                chk("R10", "rx_en", c, int'(rx_en), 0);
            end else begin
                chk("R9", "tx_en", c, int'(tx_en), 0);
                chk("R9", "ramp_en", c, int'(ramp_en), 0);
                chk("R9", "pa_en", c, int'(pa_en), 0);
                chk("R9", "tx_start", c, int'(tx_start), 0);
                chk("R9", "tx_gain", c, int'(tx_gain), 0);
                chk("R8", "bb_gain", c, int'(bb_gain), 0);
                chk("R10", "rx_en", c, int'(rx_en), auto_rx);
            end
        end
        tx_req   = 1'b0;
        phy_done = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk); #1;
        chk("R1", "tx_en", 0, int'(tx_en), 0);
        chk("R1", "tx_start", 0, int'(tx_start), 0);
        chk("R1", "ramp_en", 0, int'(ramp_en), 0);
        chk("R1", "pa_en", 0, int'(pa_en), 0);
        chk("R1", "tx_gain", 0, int'(tx_gain), 0);
        chk("R1", "bb_gain", 0, int'(bb_gain), 0);
        chk("R1", "rx_en", 0, int'(rx_en), 1);
    endtask

    task automatic t_idle_done;
        @(negedge clk);
        phy_done = 1'b1;
        #1;
        chk("R9", "idle done tx_en", 0, int'(tx_en), 0);
        chk("R9", "idle done rx_en", 0, int'(rx_en), 1);
        @(negedge clk);
        phy_done = 1'b0;
        #1;
        chk("R9", "idle done rx_en after", 1, int'(rx_en), 1);
        chk("R9", "idle done tx_gain", 1, int'(tx_gain), 0);
    endtask

    task automatic t_delays;
        run_case(3, 5, 7, 9, 2, 4, 63, 0, 0, 3, 1, 20, -1, "R2", "R4", "R5");
    endtask

    task automatic t_zero_delay;
        run_case(0, 0, 0, 0, 1, 3, 63, 0, 0, 2, 1, 6, -1, "R3", "R3", "R5");
    endtask

    task automatic t_ramp_interval;
        run_case(1, 2, 2, 4, 3, 5, 63, 0, 0, 1, 1, 25, -1, "R2", "R4", "R5");
    endtask

    task automatic t_saturate;
        run_case(0, 1, 1, 2, 1, 20, 50, 0, 0, 3, 1, 12, -1, "R2", "R4", "R6");
    endtask

    task automatic t_intv_zero;
        run_case(2, 2, 1, 3, 0, 7, 40, 0, 0, 0, 1, 12, -1, "R2", "R4", "R5");
    endtask

    task automatic t_sw_gain;
        run_case(1, 3, 2, 4, 1, 9, 63, 1, 37, 3, 1, 10, -1, "R2", "R4", "R7");
    endtask

    task automatic t_no_auto_rx;
        run_case(2, 3, 4, 5, 2, 6, 63, 0, 0, 3, 0, 9, -1, "R2", "R4", "R5");
    endtask

    task automatic t_ignore_req;
        run_case(2, 4, 3, 6, 2, 5, 63, 0, 0, 2, 1, 16, 8, "R11", "R11", "R11");
    endtask

    initial begin
        rst = 1'b1; tx_req = 1'b0; phy_done = 1'b0;
        cfg_dly_txen = '0; cfg_dly_start = '0; cfg_dly_ramp = '0; cfg_dly_pa = '0;
        cfg_gain_target = '0; cfg_gain_step = '0; cfg_step_intv = '0;
        cfg_sw_gain_mode = 1'b0; cfg_sw_gain = '0; cfg_bb_gain = '0; cfg_auto_rx = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_idle_done;
        t_delays;
        t_zero_delay;
        t_ramp_interval;
        t_saturate;
        t_intv_zero;
        t_sw_gain;
        t_no_auto_rx;
        t_delays;
        t_ignore_req;
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule